// File: doc/BRIEF.md
# Ring-of-Tables Capture Address Walker

This block produces the memory requests for a capture engine that drops a stream of 32-bit words into host memory. The host builds a ring of descriptor tables. Each table occupies one 4 KiB page: its word 0 holds the frame number of the next table, and the words after it hold the frame numbers of the data pages. A frame number becomes a byte address when it is shifted left by 12. The walker reads one table entry and fills that data page word by word from the input stream. It then moves to the next entry. After the last entry it follows the link to the next table.

Pacing comes from a credit counter. The host adds one credit for each table it hands over. Entering a table costs one credit, and this includes the first table after a start. While no credit is left, the walker issues nothing and holds its input off. The host places the first table's frame number in a configuration register and then issues commands through a single command register. The host reads the last word of a data page as that page's full flag, so the walker always writes that word last and never writes it as zero.

Top module: `ring_table_dma`

## Requirements
- R1: After reset the walker is idle. It raises no memory request and keeps `in_ready` low until a start command arrives.
- R2: Addresses are `{frame, 12-bit offset}`. Data word i of a page is at offset 4*i. Table entry e (0-based) is at offset 4*(e+1). The next-table link is at offset 0. Every request is word aligned.
- R3: For each table entry in ascending order, the walker reads the entry and then writes data words 0 to PAGE_WORDS-1 of that page in ascending order. Each write carries the input word accepted in the same cycle.
- R4: After the last entry of a table, the walker reads that table's link word and continues at entry 0 of the linked table. A link back to an earlier table closes the ring.
- R5: Entering any table consumes one credit. Writing 0x00000020 to register 0 adds one credit. With zero credit the walker issues no request and keeps `in_ready` low until a credit arrives.
- R6: When the input word destined for the last word of a page is zero, the walker writes 0x00000001 in its place. Any other value is written unchanged.
- R7: Writing 0x00000010 to register 0 sets the credit count to zero. This takes precedence over a credit taken in the same cycle.
- R8: Register 5 holds the first table's frame number. Writing 0x0C000040 to register 0 starts the walk at entry 0 of that table, with no link read before it.
- R9: Writing 0x08080000 to register 0 stops the walker. From the next cycle it issues no request and keeps `in_ready` low, and any read data still in flight is ignored. Only a new start resumes the walk.
- R10: The walker ignores a write to any register other than 0 and 5, and it ignores any other value written to register 0.
- R11: A write goes out only when `in_valid` is high, with `in_ready = mem_gnt`. A read request holds its address until it is granted. The read result is taken on the first `mem_rvalid` after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register index (0 command, 5 first table frame) |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Input word available |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | Input word accepted this cycle when `in_valid` is high |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | FRAME_W+12 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
A write request and `in_ready` depend combinationally on the same cycle's `in_valid` and `mem_gnt`. A read request appears one cycle after the state that needs it is entered. Read data returned on `mem_rvalid` produces the next request one cycle later. A command written in cycle t governs behaviour from cycle t+1. The bench drives all inputs just after the falling edge and samples 1 ns later. At that point it compares every granted request against a queue of expected transactions, built from the table contents and the credits handed out so far. Because the queue is empty whenever the credits are used up, any request while credit is exhausted or after a stop is flagged in that very cycle.

// File: rtl/ring_table_dma.sv
module ring_table_dma #(
  parameter int FRAME_W         = 32,
  parameter int PAGE_WORDS_LOG2 = 10,
  parameter int ENTRIES         = 511,
  parameter int CREDIT_W        = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [2:0]            cfg_idx,
  input  logic [31:0]           cfg_wdata,
  input  logic                  in_valid,
  input  logic [31:0]           in_data,
  output logic                  in_ready,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [FRAME_W+11:0]   mem_addr,
  output logic [31:0]           mem_wdata,
  input  logic                  mem_gnt,
  input  logic                  mem_rvalid,
  input  logic [31:0]           mem_rdata
);
  localparam int ENT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [31:0] CMD_START = 32'h0C00_0040;
  localparam logic [31:0] CMD_STOP  = 32'h0808_0000;
  localparam logic [31:0] CMD_CLR   = 32'h0000_0010;
  localparam logic [31:0] CMD_ADD   = 32'h0000_0020;

  typedef enum logic [2:0] {S_IDLE, S_CREDIT, S_ENT_RD, S_ENT_WT, S_DATA, S_LNK_RD, S_LNK_WT} st_t;

  st_t                        st;
  logic [FRAME_W-1:0]         tbl_frm, pg_frm, first_frm;
  logic [ENT_W-1:0]           ent;
  logic [PAGE_WORDS_LOG2-1:0] wrd;
  logic [CREDIT_W-1:0]        credit;
  logic                       need_link;
  logic [11:0]                off;

  wire cmd_wr     = cfg_we && cfg_idx == 3'd0;
  wire cmd_start  = cmd_wr && cfg_wdata == CMD_START;
  wire cmd_stop   = cmd_wr && cfg_wdata == CMD_STOP;
  wire cmd_clr    = cmd_wr && cfg_wdata == CMD_CLR;
  wire cmd_add    = cmd_wr && cfg_wdata == CMD_ADD;
  wire take       = st == S_CREDIT && credit != '0 && !cmd_start && !cmd_stop;
  wire wr_fire    = st == S_DATA && in_valid && mem_gnt;
  wire last_word  = &wrd;
  wire last_ent   = ent == ENT_W'(ENTRIES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      credit <= '0;
      first_frm <= '0;
    end else begin
      if (cmd_clr) credit <= '0;
      else credit <= credit + CREDIT_W'(cmd_add) - CREDIT_W'(take);
      if (cfg_we && cfg_idx == 3'd5) first_frm <= cfg_wdata[FRAME_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      tbl_frm <= '0;
      pg_frm <= '0;
      ent <= '0;
      wrd <= '0;
      need_link <= 1'b0;
    end else if (cmd_stop) begin
      st <= S_IDLE;
    end else if (cmd_start) begin
      tbl_frm <= first_frm;
      need_link <= 1'b0;
      st <= S_CREDIT;
    end else begin
      unique case (st)
        S_CREDIT: if (take) begin
          ent <= '0;
          st <= need_link ? S_LNK_RD : S_ENT_RD;
        end
        S_ENT_RD: if (mem_gnt) st <= S_ENT_WT;
        S_ENT_WT: if (mem_rvalid) begin
          pg_frm <= mem_rdata[FRAME_W-1:0];
          wrd <= '0;
          st <= S_DATA;
        end
        S_DATA: if (wr_fire) begin
          wrd <= wrd + 1'b1;
          if (last_word) begin
            if (last_ent) begin
              need_link <= 1'b1;
              st <= S_CREDIT;
            end else begin
              ent <= ent + 1'b1;
              st <= S_ENT_RD;
            end
          end
        end
        S_LNK_RD: if (mem_gnt) st <= S_LNK_WT;
        S_LNK_WT: if (mem_rvalid) begin
          tbl_frm <= mem_rdata[FRAME_W-1:0];
          need_link <= 1'b0;
          st <= S_ENT_RD;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (st)
      S_ENT_RD: off = 12'((32'(ent) + 32'd1) << 2);
      S_DATA:   off = 12'(32'(wrd) << 2);
      default:  off = 12'd0;
    endcase
  end

  assign mem_req   = st == S_ENT_RD || st == S_LNK_RD || (st == S_DATA && in_valid);
  assign mem_we    = st == S_DATA;
  assign mem_addr  = {(st == S_DATA) ? pg_frm : tbl_frm, off};
  assign mem_wdata = (last_word && in_data == 32'd0) ? 32'd1 : in_data;
  assign in_ready  = st == S_DATA && mem_gnt;
endmodule

// File: rtl/ring_table_dma_chk.sv
module ring_table_dma_chk #(
  parameter int FRAME_W         = 32,
  parameter int PAGE_WORDS_LOG2 = 10,
  parameter int CREDIT_W        = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_we,
  input logic [2:0]          cfg_idx,
  input logic [31:0]         cfg_wdata,
  input logic                in_ready,
  input logic                mem_req,
  input logic                mem_we,
  input logic [FRAME_W+11:0] mem_addr,
  input logic [31:0]         mem_wdata,
  input logic                mem_gnt,
  input logic                at_gate,
  input logic [CREDIT_W-1:0] credit
);
  localparam int AW = FRAME_W + 12;
  wire cmd0 = cfg_we && cfg_idx == 3'd0;
  wire lastw = &mem_addr[PAGE_WORDS_LOG2+1:2];

  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  a_r3_sequential_words: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && $past(mem_req && mem_we && mem_gnt)) |-> mem_addr == $past(mem_addr) + AW'(4));

  a_r6_last_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && lastw) |-> mem_wdata != 32'd0);

  a_r11_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && !mem_gnt && !cfg_we) |=> (mem_req && !mem_we && $stable(mem_addr)));

  a_r11_ready_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (mem_gnt && mem_we));

  a_r9_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd0 && cfg_wdata == 32'h0808_0000) |=> (!mem_req && !in_ready));

  a_r5_no_credit_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (at_gate && credit == '0 && !cfg_we) |=> !mem_req);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd0 && cfg_wdata == 32'h0000_0010) |=> credit == '0);
endmodule

bind ring_table_dma ring_table_dma_chk #(
  .FRAME_W(FRAME_W), .PAGE_WORDS_LOG2(PAGE_WORDS_LOG2), .CREDIT_W(CREDIT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
  .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .at_gate(st == S_CREDIT), .credit(credit)
);

// File: tb/ring_table_dma_test.sv
`timescale 1ns/1ps
module ring_table_dma_test;
  localparam int PWL = 3;
  localparam int PW  = 1 << PWL;
  localparam int NE  = 3;
  localparam logic [31:0] START = 32'h0C00_0040, STOP = 32'h0808_0000;
  localparam logic [31:0] CLR = 32'h10, ADD = 32'h20;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [2:0] cfg_idx = 0; logic [31:0] cfg_wdata = 0;
  logic in_valid = 0; logic [31:0] in_data = 0; logic in_ready;
  logic mem_req, mem_we; logic [43:0] mem_addr; logic [31:0] mem_wdata;
  logic mem_gnt = 0, mem_rvalid = 0; logic [31:0] mem_rdata = 0;

  ring_table_dma #(.FRAME_W(32), .PAGE_WORDS_LOG2(PWL), .ENTRIES(NE), .CREDIT_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  always #2.5 clk = ~clk;

  typedef struct packed { logic we; logic [43:0] addr; } ev_t;
  ev_t exq[$];
  int nchk = 0, nfail = 0, k = 0, nwr = 0;
  bit rd_pend = 0; logic [43:0] rd_addr = 0;

  task automatic check(input bit ok, input string msg);
    nchk++;
    if (!ok) begin nfail++; $display("FAIL %s", msg); end
  endtask

  function automatic logic [31:0] gen(input int n);
    return (n % 3 == 0) ? 32'd0 : 32'hA500_0000 + 32'(n);
  endfunction

  function automatic logic [31:0] rd_mem(input logic [43:0] a);
    logic [31:0] f = a[43:12]; logic [9:0] o = a[11:2];
    if (f == 32'h100) return (o == 0) ? 32'h200 : 32'h1000 + 32'(o);
    if (f == 32'h200) return (o == 0) ? 32'h100 : 32'h2000 + 32'(o);
    return 32'd0;
  endfunction

  task automatic push_table(input logic [31:0] tf, input bit with_link, input logic [31:0] prev);
    if (with_link) exq.push_back('{we: 1'b0, addr: {prev, 12'h000}});
    for (int e = 0; e < NE; e++) begin
      logic [31:0] pf = rd_mem({tf, 12'((e + 1) * 4)});
      exq.push_back('{we: 1'b0, addr: {tf, 12'((e + 1) * 4)}});
      for (int w = 0; w < PW; w++) exq.push_back('{we: 1'b1, addr: {pf, 12'(w * 4)}});
    end
  endtask

  task automatic cyc(input bit we, input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = we; cfg_idx = idx; cfg_wdata = d;
    mem_gnt = ($urandom % 4) != 0;
    in_valid = ($urandom % 4) != 0;
    in_data = gen(k);
    mem_rvalid = rd_pend; mem_rdata = rd_pend ? rd_mem(rd_addr) : 32'd0;
    rd_pend = 0;
    #1;
    if (mem_req && mem_gnt) begin
      if (exq.size() == 0)
        check(0, $sformatf("R5/R9 unexpected request addr=%h we=%0b expected none", mem_addr, mem_we));
      else begin
        ev_t ev = exq.pop_front();
        check(ev.we == mem_we && ev.addr == mem_addr,
              $sformatf("R2/R3/R4 request we=%0b addr=%h expected we=%0b addr=%h", mem_we, mem_addr, ev.we, ev.addr));
        if (mem_we) begin
          logic [31:0] ex = (ev.addr[PWL+1:2] == '1 && in_data == 0) ? 32'd1 : in_data;
          check(mem_wdata == ex && in_valid && in_ready,
                $sformatf("R3/R6/R11 write data=%h ready=%0b expected data=%h ready=1", mem_wdata, in_ready, ex));
          nwr++;
        end else begin
          rd_pend = 1; rd_addr = mem_addr;
        end
      end
    end
    if (in_valid && in_ready && !(mem_req && mem_we && mem_gnt))
      check(0, $sformatf("R11 input taken without write req=%0b we=%0b expected write", mem_req, mem_we));
    if (in_valid && in_ready) k++;
  endtask

  task automatic run_empty(input string tag);
    int n = 0;
    while (exq.size() > 0 && n < 3000) begin cyc(0, 0, 0); n++; end
    check(exq.size() == 0, $sformatf("%s walk left %0d transactions expected 0", tag, exq.size()));
  endtask

  task automatic quiet(input int n, input string tag);
    bit bad = 0;
    for (int i = 0; i < n; i++) begin
      cyc(0, 0, 0);
      if (mem_req || in_ready) bad = 1;
    end
    check(!bad, $sformatf("%s activity seen=%0b expected 0", tag, bad));
  endtask

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) cyc(0, 0, 0);
    @(negedge clk); rst_n = 1;
    quiet(6, "R1 idle after reset");

    cyc(1, 5, 32'h100); cyc(1, 0, CLR); cyc(1, 0, ADD);
    cyc(1, 3, START);
    quiet(4, "R10 start value to other register");
    cyc(1, 0, START);
    push_table(32'h100, 0, 0);
    repeat (10) cyc(0, 0, 0);
    cyc(1, 0, 32'h1); cyc(1, 2, STOP);
    run_empty("R8 first table");
    quiet(20, "R5 stall without credit");

    cyc(1, 0, ADD);
    push_table(32'h200, 1, 32'h100);
    run_empty("R4 link to second table");
    cyc(1, 0, ADD);
    push_table(32'h100, 1, 32'h200);
    run_empty("R4 ring back to first table");
    quiet(10, "R5 stall after ring");

    cyc(1, 0, ADD);
    push_table(32'h200, 1, 32'h100);
    nwr = 0;
    for (int i = 0; i < 2000 && nwr < 6; i++) cyc(0, 0, 0);
    cyc(1, 0, STOP);
    exq.delete();
    quiet(20, "R9 no activity after stop");

    cyc(1, 5, 32'h200); cyc(1, 0, ADD); cyc(1, 0, ADD); cyc(1, 0, CLR);
    cyc(1, 0, START);
    quiet(15, "R7 clear leaves no credit");
    cyc(1, 0, ADD);
    push_table(32'h200, 0, 0);
    run_empty("R8 restart at register 5 table");
    quiet(10, "R5 stall after restart");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule